// File: doc/BRIEF.md
# Comparator Timer Channel

One channel of an event timer block. The channel watches a shared free-running main counter. It raises a one-cycle expiry pulse toward the interrupt logic when the counter reaches the channel's armed target. Software reaches a configuration register and a comparator register through a narrow word port, where one select bit picks the register and one bit picks the lower or upper half.

The channel runs in one-shot or periodic mode. In periodic mode, software writes go to a hidden period register. The visible comparator takes a write only when the value-set bit is 1, and after each expiry the comparator steps forward by the period. A 32-bit mode matches only the low half of the counter. In that mode a one-shot target that lies past the next 32-bit rollover produces an extra expiry at the rollover before the real one. The channel re-derives its target from the counter whenever software writes configuration or comparator while the block is globally enabled, and when the global enable rises.

Top module: `tmr_chan`

## Requirements
- R1: After reset the configuration reads 0x0030 in its low half (bit 4 periodic-capable, bit 5 wide-capable) and ROUTE_CAP in its high half. The comparator reads all ones and `fire_o` is low.
- R2: A configuration write to the low half changes only the bits set in 0x7F4E. Bits 4 and 5 stay 1 and all other bits read 0. Writes to the high half of the configuration have no effect.
- R3: A comparator write clears the value-set bit (bit 6). In one-shot mode (bit 3 = 0) the write lands in the addressed half of the comparator.
- R4: When a configuration write leaves bit 8 (32-bit mode) set, the upper halves of the comparator and the period become zero.
- R5: In periodic mode (bit 3 = 1) a comparator write always updates the period. It updates the visible comparator only if value-set is 1.
- R6: In 32-bit mode a write to the comparator's upper half is discarded, and a write to its lower half zeroes the upper half.
- R7: In one-shot mode the channel fires once when the counter equals or passes the target. The comparison uses the sign of (counter − target), so a target just past the 64-bit rollover is awaited correctly.
- R8: In periodic mode with a nonzero period, each expiry advances the target by the period until it is ahead of the counter. The visible comparator follows the target, and a counter jump over several periods yields one pulse.
- R9: In 32-bit mode the target is the counter with its low half replaced by the comparator, plus 2^32 if that is below the counter. In one-shot mode, when that target exceeds the next rollover, the channel fires first at the rollover and then at the target.
- R10: No expiry occurs while `glb_en_i` is low. The target is re-evaluated when the enable rises, and on every accepted configuration or comparator write made while enabled.
- R11: Each match event gives a pulse of exactly one cycle on `fire_o`, even if the counter stays past the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Shared main counter value |
| glb_en_i | input | 1 | Global enable of the timer block |
| wr_en_i | input | 1 | Register write strobe |
| sel_i | input | 1 | Register select: 0 configuration, 1 comparator |
| half_i | input | 1 | Half select: 0 lower, 1 upper |
| wdata_i | input | CNT_W/2 | Write data |
| rdata_o | output | CNT_W/2 | Read data of the selected register half (combinational) |
| fire_o | output | 1 | One-cycle expiry pulse |

## Verification
Register reads are combinational, so the bench checks them one time unit after it sets the select lines. A write takes effect at the next rising edge. The new target is armed one edge after that, so the bench holds the counter below the target across those two edges. `fire_o` is registered: a counter value presented before edge e that meets the target shows as `fire_o` high between edge e and edge e+1. The bench drives each counter value after a falling edge and samples `fire_o` at the next falling edge, which lets it attribute every pulse to the exact counter value that caused it. A periodic catch-up spends one cycle per period step, so after a counter jump the bench holds the counter steady for several cycles before it reads the comparator.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CFG_W = 16;
  localparam logic [CFG_W-1:0] CFG_WMASK = 16'h7F4E;
  localparam logic [CFG_W-1:0] CFG_RST   = 16'h0030;
  localparam int B_PER  = 3;
  localparam int B_VSET = 6;
  localparam int B_M32  = 8;
  typedef enum logic {SEL_CFG = 1'b0, SEL_CMP = 1'b1} reg_sel_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs import tmr_pkg::*; #(
  parameter int CNT_W = 64,
  localparam int HW = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             sel_i,
  input  logic             half_i,
  input  logic [HW-1:0]    wdata_i,
  input  logic             adv_en_i,
  input  logic [CNT_W-1:0] adv_val_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CNT_W-1:0] per_o,
  output logic             rearm_o
);
  logic [CFG_W-1:0] cfg_q, cfg_new;
  logic [CNT_W-1:0] cmp_q, per_q, cmp_dep, per_dep;
  logic m32, per_m, wr_cfg, wr_cmp;

  assign m32    = cfg_q[B_M32];
  assign per_m  = cfg_q[B_PER];
  assign wr_cfg = wr_en_i && (sel_i == SEL_CFG) && !half_i;
  // upper comparator half is dropped in 32-bit mode
  assign wr_cmp = wr_en_i && (sel_i == SEL_CMP) && !(m32 && half_i);
  assign cfg_new = (wdata_i[CFG_W-1:0] & CFG_WMASK) | (cfg_q & ~CFG_WMASK);

  function automatic logic [CNT_W-1:0] put_half(input logic [CNT_W-1:0] old,
                                                input logic [HW-1:0] d,
                                                input logic hi, input logic narrow);
    if (narrow)  return {{HW{1'b0}}, d};
    else if (hi) return {d, old[HW-1:0]};
    else         return {old[CNT_W-1:HW], d};
  endfunction

  assign cmp_dep = put_half(cmp_q, wdata_i, half_i, m32);
  assign per_dep = put_half(per_q, wdata_i, half_i, m32);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      cmp_q <= '1;
      per_q <= '0;
    end else if (wr_cfg) begin
      cfg_q <= cfg_new;
      if (cfg_new[B_M32]) begin
        cmp_q[CNT_W-1:HW] <= '0;
        per_q[CNT_W-1:HW] <= '0;
      end
    end else if (wr_cmp) begin
      if (!per_m || cfg_q[B_VSET]) cmp_q <= cmp_dep;
      if (per_m) per_q <= per_dep;
      cfg_q[B_VSET] <= 1'b0;
    end else if (adv_en_i) begin
      cmp_q <= adv_val_i;
    end
  end

  assign cfg_o   = cfg_q;
  assign cmp_o   = cmp_q;
  assign per_o   = per_q;
  assign rearm_o = wr_cfg || wr_cmp;

  p_vset_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp |=> !cfg_q[B_VSET]);
  p_trunc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m32 |-> (cmp_q[CNT_W-1:HW] == '0 && per_q[CNT_W-1:HW] == '0));
  p_hi_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_i == SEL_CMP && half_i && m32) |=> $stable(cmp_q[CNT_W-1:HW]));
endmodule

// File: rtl/tmr_target.sv
module tmr_target #(
  parameter int CNT_W = 64,
  localparam int HW = CNT_W / 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             m32_i,
  input  logic             per_i,
  output logic [CNT_W-1:0] tgt_o,
  output logic [CNT_W-1:0] stop_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] HALF_ONE = {{(HW-1){1'b0}}, 1'b1, {HW{1'b0}}};
  logic [CNT_W-1:0] t_low, t_adj, nwrap;

  assign t_low  = {cnt_i[CNT_W-1:HW], cmp_i[HW-1:0]};
  assign t_adj  = (t_low < cnt_i) ? t_low + HALF_ONE : t_low;
  assign nwrap  = {cnt_i[CNT_W-1:HW] + 1'b1, {HW{1'b0}}};
  assign tgt_o  = m32_i ? t_adj : cmp_i;
  assign wrap_o = m32_i && !per_i && (t_adj > nwrap);
  assign stop_o = wrap_o ? nwrap : tgt_o;
endmodule

// File: rtl/tmr_seq.sv
module tmr_seq #(
  parameter int CNT_W = 64,
  localparam int HW = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             glb_en_i,
  input  logic             wr_rearm_i,
  input  logic             per_mode_i,
  input  logic             m32_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] tgt_i,
  input  logic [CNT_W-1:0] stop_i,
  input  logic             wrap_i,
  output logic             adv_en_o,
  output logic [CNT_W-1:0] adv_val_o,
  output logic             fire_o
);
  logic en_q, rearm_q, armed_q, wrap_q, adv_q, fire_q;
  logic [CNT_W-1:0] tgt_q, full_q, diff, nxt;
  logic reached, hit, per_go;

  assign diff    = cnt_i - tgt_q;
  assign reached = !diff[CNT_W-1];
  assign hit     = glb_en_i && armed_q && !rearm_q && !adv_q && reached;
  assign nxt     = tgt_q + per_i;
  assign per_go  = per_mode_i && (per_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      rearm_q <= 1'b0;
      armed_q <= 1'b0;
      wrap_q  <= 1'b0;
      adv_q   <= 1'b0;
      fire_q  <= 1'b0;
      tgt_q   <= '0;
      full_q  <= '0;
    end else begin
      en_q    <= glb_en_i;
      rearm_q <= glb_en_i && (wr_rearm_i || !en_q);
      fire_q  <= hit;
      if (!glb_en_i) begin
        armed_q <= 1'b0;
        wrap_q  <= 1'b0;
        adv_q   <= 1'b0;
      end else if (rearm_q) begin
        armed_q <= 1'b1;
        tgt_q   <= stop_i;
        full_q  <= tgt_i;
        wrap_q  <= wrap_i;
        adv_q   <= 1'b0;
      end else if (hit) begin
        if (wrap_q) begin
          tgt_q  <= full_q;
          wrap_q <= 1'b0;
        end else if (per_go) begin
          tgt_q  <= nxt;
          full_q <= nxt;
          adv_q  <= 1'b1;
        end else begin
          armed_q <= 1'b0;
        end
      end else if (adv_q) begin
        // catch-up: step until the target is strictly ahead of the counter
        if (reached) begin
          tgt_q  <= nxt;
          full_q <= nxt;
        end else begin
          adv_q <= 1'b0;
        end
      end
    end
  end

  assign adv_en_o  = glb_en_i && !rearm_q &&
                     ((hit && !wrap_q && per_go) || (adv_q && reached));
  assign adv_val_o = m32_i ? {{HW{1'b0}}, nxt[HW-1:0]} : nxt;
  assign fire_o    = fire_q;

  p_no_fire_dis_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> !fire_o);
  p_adv_ahead_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(adv_q) && $past(glb_en_i) && !$past(rearm_q)) |->
      ($signed($past(cnt_i) - tgt_q) < 0));
  p_oneshot_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !wrap_q && !per_mode_i) |=> !armed_q);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; #(
  parameter int CNT_W = 64,
  parameter logic [CNT_W/2-1:0] ROUTE_CAP = 32'h0000_0F00,
  localparam int HW = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             glb_en_i,
  input  logic             wr_en_i,
  input  logic             sel_i,
  input  logic             half_i,
  input  logic [HW-1:0]    wdata_i,
  output logic [HW-1:0]    rdata_o,
  output logic             fire_o
);
  logic [CFG_W-1:0] cfg;
  logic [CNT_W-1:0] cmp, per, adv_val, tgt, stop;
  logic adv_en, rearm, wrap;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .sel_i, .half_i, .wdata_i,
    .adv_en_i(adv_en), .adv_val_i(adv_val),
    .cfg_o(cfg), .cmp_o(cmp), .per_o(per), .rearm_o(rearm));

  tmr_target #(.CNT_W(CNT_W)) u_tgt (
    .cnt_i, .cmp_i(cmp), .m32_i(cfg[B_M32]), .per_i(cfg[B_PER]),
    .tgt_o(tgt), .stop_o(stop), .wrap_o(wrap));

  tmr_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .cnt_i, .glb_en_i, .wr_rearm_i(rearm),
    .per_mode_i(cfg[B_PER]), .m32_i(cfg[B_M32]), .per_i(per),
    .tgt_i(tgt), .stop_i(stop), .wrap_i(wrap),
    .adv_en_o(adv_en), .adv_val_o(adv_val), .fire_o);

  always_comb begin
    if (sel_i == SEL_CFG) rdata_o = half_i ? ROUTE_CAP : {{(HW-CFG_W){1'b0}}, cfg};
    else                  rdata_o = half_i ? cmp[CNT_W-1:HW] : cmp[HW-1:0];
  end
endmodule

// File: tb/tmr_chan_tb_top.sv
module tmr_chan_tb_top;
  localparam logic [31:0] RCAP = 32'h0000_0F00;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [63:0] cnt = '0;
  logic glb_en = 1'b0, wr_en = 1'b0, sel = 1'b0, half = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic fire;
  int n_run = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  tmr_chan dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .glb_en_i(glb_en),
    .wr_en_i(wr_en), .sel_i(sel), .half_i(half), .wdata_i(wdata),
    .rdata_o(rdata), .fire_o(fire));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic s, input logic h, input logic [31:0] d);
    sel = s; half = h; wdata = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, input logic h, input logic [31:0] exp, input string tag);
    sel = s; half = h;
    #1;
    chk(tag, {32'b0, rdata}, {32'b0, exp});
  endtask

  task automatic arm();
    glb_en = 1'b1;
    step();
    step();
  endtask

  task automatic run(input logic [63:0] start, input int n, input logic [63:0] stp,
                     output int nf, output logic [63:0] first, output logic [63:0] last);
    logic [63:0] c;
    c = start; nf = 0; first = '0; last = '0;
    for (int i = 0; i < n; i++) begin
      cnt = c;
      step();
      if (fire) begin
        if (nf == 0) first = c;
        nf++;
        last = c;
      end
      c = c + stp;
    end
  endtask

  task automatic hold(input int n, output int nf);
    nf = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (fire) nf++;
    end
  endtask

  // expected expiries for a one-shot channel armed with counter c0
  task automatic exp_fires(input logic [63:0] c0, input logic [63:0] cv, input logic m32,
                           output int n, output logic [63:0] first, output logic [63:0] last);
    logic [63:0] t, nw;
    if (!m32) begin
      n = 1; first = cv; last = cv;
    end else begin
      t = {c0[63:32], cv[31:0]};
      if (t < c0) t = t + 64'h1_0000_0000;
      nw = {c0[63:32] + 32'd1, 32'b0};
      last = t;
      if (t > nw) begin n = 2; first = nw; end
      else begin n = 1; first = t; end
    end
  endtask

  initial begin
    #(4 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int nf, en;
    logic [63:0] f, l, ef, el, base, tv;
    logic m;
    void'($urandom(32'd4711));
    step(); step();
    rst_ni = 1'b1;
    step();

    // R1 reset state
    rd(1'b0, 1'b0, 32'h0000_0030, "R1 cfg lo");
    rd(1'b0, 1'b1, RCAP, "R1 cfg hi");
    rd(1'b1, 1'b0, 32'hFFFF_FFFF, "R1 cmp lo");
    rd(1'b1, 1'b1, 32'hFFFF_FFFF, "R1 cmp hi");
    chk("R1 fire", {63'b0, fire}, 64'd0);

    // R2 mask, R4 truncation on entering 32-bit mode
    wr(1'b0, 1'b0, 32'hFFFF_FFFF);
    rd(1'b0, 1'b0, 32'h0000_7F7E, "R2 cfg mask");
    wr(1'b0, 1'b1, 32'h1234_5678);
    rd(1'b0, 1'b1, RCAP, "R2 cfg hi ro");
    rd(1'b1, 1'b1, 32'h0, "R4 cmp hi trunc");
    rd(1'b1, 1'b0, 32'hFFFF_FFFF, "R4 cmp lo kept");
    wr(1'b0, 1'b0, 32'h0);
    rd(1'b0, 1'b0, 32'h0000_0030, "R2 cfg clear");

    // R6 upper half discarded in 32-bit mode
    wr(1'b0, 1'b0, 32'h0000_0100);
    wr(1'b1, 1'b1, 32'h0000_ABCD);
    rd(1'b1, 1'b1, 32'h0, "R6 hi dropped");
    wr(1'b1, 1'b0, 32'h0000_0055);
    rd(1'b1, 1'b0, 32'h0000_0055, "R6 lo write");
    wr(1'b0, 1'b0, 32'h0);

    // R3 one-shot writes, value-set clear
    wr(1'b1, 1'b1, 32'h0000_0001);
    wr(1'b1, 1'b0, 32'h0000_0100);
    rd(1'b1, 1'b1, 32'h1, "R3 cmp hi");
    rd(1'b1, 1'b0, 32'h100, "R3 cmp lo");
    wr(1'b0, 1'b0, 32'h0000_0040);
    wr(1'b1, 1'b0, 32'h0000_0100);
    rd(1'b0, 1'b0, 32'h0000_0030, "R3 vset cleared");

    // R7 / R11 one-shot 64-bit
    cnt = 64'h1_0000_00F0;
    arm();
    run(64'h1_0000_00F0, 40, 64'd1, nf, f, l);
    chk("R7 count", nf, 1);
    chk("R7 match", l, 64'h1_0000_0100);

    // R7 target just past the 64-bit rollover
    glb_en = 1'b0; step();
    wr(1'b1, 1'b1, 32'h0);
    wr(1'b1, 1'b0, 32'h5);
    cnt = 64'hFFFF_FFFF_FFFF_FFF0;
    arm();
    run(64'hFFFF_FFFF_FFFF_FFF0, 30, 64'd1, nf, f, l);
    chk("R7 roll count", nf, 1);
    chk("R7 roll match", l, 64'h5);

    // R5 / R8 periodic
    glb_en = 1'b0; step();
    wr(1'b0, 1'b0, 32'h0000_0048);
    wr(1'b1, 1'b0, 32'h0000_0200);
    rd(1'b0, 1'b0, 32'h0000_0038, "R5 vset cleared");
    wr(1'b1, 1'b0, 32'h0000_0040);
    rd(1'b1, 1'b0, 32'h0000_0200, "R5 cmp kept");
    cnt = 64'h1F0;
    arm();
    run(64'h1F0, 177, 64'd1, nf, f, l);
    chk("R8 periodic count", nf, 3);
    chk("R8 first", f, 64'h200);
    chk("R8 last", l, 64'h280);
    rd(1'b1, 1'b0, 32'h0000_02C0, "R8 cmp advanced");
    cnt = 64'h3F5;
    hold(8, nf);
    chk("R8 jump one pulse", nf, 1);
    rd(1'b1, 1'b0, 32'h0000_0400, "R8 catch-up");

    // R9 32-bit one-shot with rollover pre-fire
    glb_en = 1'b0; step();
    wr(1'b0, 1'b0, 32'h0000_0100);
    wr(1'b1, 1'b0, 32'h0000_0010);
    cnt = 64'h5_FFFF_FFF0;
    arm();
    run(64'h5_FFFF_FFF0, 48, 64'd1, nf, f, l);
    chk("R9 wrap count", nf, 2);
    chk("R9 wrap first", f, 64'h6_0000_0000);
    chk("R9 wrap last", l, 64'h6_0000_0010);
    glb_en = 1'b0; step();
    wr(1'b1, 1'b0, 32'h0);
    cnt = 64'h5_FFFF_FFF0;
    arm();
    run(64'h5_FFFF_FFF0, 40, 64'd1, nf, f, l);
    chk("R9 at wrap count", nf, 1);
    chk("R9 at wrap match", l, 64'h6_0000_0000);

    // R10 / R11 enable gating and re-evaluation
    glb_en = 1'b0; step();
    wr(1'b0, 1'b0, 32'h0);
    wr(1'b1, 1'b1, 32'h0);
    wr(1'b1, 1'b0, 32'h0000_1000);
    run(64'hFF0, 40, 64'd1, nf, f, l);
    chk("R10 disabled", nf, 0);
    cnt = 64'h2000;
    glb_en = 1'b1;
    hold(6, nf);
    chk("R11 single pulse", nf, 1);
    cnt = 64'h2100;
    wr(1'b1, 1'b0, 32'h0000_3000);
    step();
    run(64'h2FF0, 40, 64'd1, nf, f, l);
    chk("R10 rearm count", nf, 1);
    chk("R10 rearm match", l, 64'h3000);

    // random one-shot runs, 64-bit (R7) and 32-bit (R9)
    for (int it = 0; it < 30; it++) begin
      m = it[0];
      glb_en = 1'b0; step();
      base = {1'b0, 31'($urandom), 32'($urandom)};
      if (it % 4 == 1) base[31:0] = 32'hFFFF_FFFF - ($urandom % 40);
      tv = base + 64'(1 + $urandom % 50);
      wr(1'b0, 1'b0, m ? 32'h0000_0100 : 32'h0);
      if (!m) wr(1'b1, 1'b1, tv[63:32]);
      wr(1'b1, 1'b0, tv[31:0]);
      cnt = base;
      arm();
      exp_fires(base, tv, m, en, ef, el);
      run(base, 70, 64'd1, nf, f, l);
      chk(m ? "R9 rnd count" : "R7 rnd count", nf, en);
      chk(m ? "R9 rnd first" : "R7 rnd first", f, ef);
      chk(m ? "R9 rnd last" : "R7 rnd last", l, el);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule